// File: doc/BRIEF.md
# Memory Region Permission Checker

This block guards a memory map on behalf of up to eight bus masters. It holds a parameterised set of region descriptors. Each descriptor has an inclusive start address, an inclusive end address, a 32-bit permission word and an enable flag. Software programs the descriptors over a simple word-wide register bus. Every access presented on the check port is answered in the same cycle with either a grant or an error.

Masters 4 to 7 carry a plain read/write enable pair. Masters 0 to 3 carry a six-bit group with a user-mode read/write/execute triple and a two-bit supervisor selector. A second register address per region, the alias, rewrites the permission word and leaves the enable flag as it is. Permissions can therefore be retuned while the region stays live. Writing any of the address or permission words through the main window disables the region until software enables it again.

The block has no state machine. The only sequential state is the descriptor storage, which is updated in one process. Readback and access decisions come from combinational processes.

Top module: `mpu_region_checker`

## Requirements
- R1: After reset every descriptor word reads 0, every region is disabled, and any access gets an error.
- R2: Byte address 0x400 + 16*n + 4*w selects word w of region n: w=0 start, w=1 end, w=2 permission word, w=3 control with the enable flag in bit 0. All of these read back as written. Unmapped or misaligned addresses read 0 and ignore writes.
- R3: Writing word 0, 1 or 2 of a region clears its enable flag. Writing word 3 loads the enable flag from bit 0 of the write data.
- R4: The alias at byte address 0x800 + 4*n writes and reads region n's permission word and leaves its enable flag unchanged.
- R5: A region covers an access when it is enabled and start <= address <= end, both bounds included. An access that no enabled region covers gets an error.
- R6: For master m in 4..7, the read enable is permission bit 2m+17 and the write enable is bit 2m+16. A fetch is judged by the read enable. Privilege has no effect.
- R7: For master m in 0..3, the group at bits [6m+5:6m] holds a spare flag in bit 6m+5 with no effect on decisions, the supervisor selector in [6m+4:6m+3], and the user triple with read at 6m+2, write at 6m+1 and execute at 6m.
- R8: A user-mode access by masters 0..3 is allowed only if the user bit for its kind is set. The kind is write when acc_write=1, otherwise execute when acc_fetch=1, otherwise read.
- R9: Supervisor selector codes for masters 0..3: 0 allows read/write/execute, 1 allows read/execute, 2 allows read/write, 3 uses the user triple.
- R10: With overlapping regions, an access is granted if any covering enabled region allows it.
- R11: The response is combinational in the cycle of the request. When acc_valid=1, exactly one of acc_grant and acc_error is high. When acc_valid=0, both are low.
- R12: An access in the same cycle as a register write is judged against the descriptors as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_master | input | 3 | Requesting master number |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_grant | output | 1 | Access allowed |
| acc_error | output | 1 | Access refused |

## Verification
A descriptor write and an access check can land in the same cycle. The concern is that the check must see the old descriptor. The bench drives a write to a live region's start word, or to its alias, on the same falling edge as an access that the old settings grant. It judges the response before the next rising edge, where the old grant must still stand. It then repeats the access after the edge, where the disabled region must refuse it, or the retuned permissions must apply.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SUP_RWX     = 2'd0,
        SUP_RX      = 2'd1,
        SUP_RW      = 2'd2,
        SUP_AS_USER = 2'd3
    } sup_mode_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rwx_t;

    localparam int WORD_START = 0;
    localparam int WORD_END   = 1;
    localparam int WORD_PERM  = 2;
    localparam int WORD_CTRL  = 3;
    localparam int WORDS_PER_REGION = 4;

endpackage

// File: rtl/mpu_desc_regs.sv
module mpu_desc_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    parameter int CFG_AW      = 12,
    parameter int DESC_BASE   = 'h400,
    parameter int ALT_BASE    = 'h800
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [CFG_AW-1:0]                    cfg_addr,
    input  logic [31:0]                          cfg_wdata,
    output logic [31:0]                          cfg_rdata,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   start_o,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   end_o,
    output logic [NUM_REGIONS-1:0][31:0]         perm_o,
    output logic [NUM_REGIONS-1:0]               valid_o
);

    localparam int WA = CFG_AW - 2;

    logic [WA-1:0]                         word_idx;
    logic                                  aligned;
    logic [NUM_REGIONS-1:0][WORDS_PER_REGION-1:0] sel_word;
    logic [NUM_REGIONS-1:0]                sel_alt;

    logic [NUM_REGIONS-1:0][ADDR_W-1:0]    start_q;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]    end_q;
    logic [NUM_REGIONS-1:0][31:0]          perm_q;
    logic [NUM_REGIONS-1:0]                valid_q;

    assign word_idx = cfg_addr[CFG_AW-1:2];
    assign aligned  = (cfg_addr[1:0] == 2'b00);

    for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_sel
        for (genvar w = 0; w < WORDS_PER_REGION; w++) begin : g_word
            localparam int WORD_NUM = (DESC_BASE / 4) + WORDS_PER_REGION * n + w;
            assign sel_word[n][w] = aligned && (word_idx == WA'(WORD_NUM));
        end
        localparam int ALT_NUM = (ALT_BASE / 4) + n;
        assign sel_alt[n] = aligned && (word_idx == WA'(ALT_NUM));
    end

    // Descriptor storage: the only sequential process of the block.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            perm_q  <= '0;
            valid_q <= '0;
        end else if (cfg_we) begin
            for (int n = 0; n < NUM_REGIONS; n++) begin
                if (sel_word[n][WORD_START]) begin
                    start_q[n] <= cfg_wdata[ADDR_W-1:0];
                    valid_q[n] <= 1'b0;
                end
                if (sel_word[n][WORD_END]) begin
                    end_q[n]   <= cfg_wdata[ADDR_W-1:0];
                    valid_q[n] <= 1'b0;
                end
                if (sel_word[n][WORD_PERM]) begin
                    perm_q[n]  <= cfg_wdata;
                    valid_q[n] <= 1'b0;
                end
                if (sel_word[n][WORD_CTRL]) begin
                    valid_q[n] <= cfg_wdata[0];
                end
                if (sel_alt[n]) begin
                    perm_q[n]  <= cfg_wdata;
                end
            end
        end
    end

    // Readback mux.
    always_comb begin
        cfg_rdata = '0;
        for (int n = 0; n < NUM_REGIONS; n++) begin
            if (sel_word[n][WORD_START]) cfg_rdata = 32'(start_q[n]);
            if (sel_word[n][WORD_END])   cfg_rdata = 32'(end_q[n]);
            if (sel_word[n][WORD_PERM])  cfg_rdata = perm_q[n];
            if (sel_word[n][WORD_CTRL])  cfg_rdata = {31'b0, valid_q[n]};
            if (sel_alt[n])              cfg_rdata = perm_q[n];
        end
    end

    assign start_o = start_q;
    assign end_o   = end_q;
    assign perm_o  = perm_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic              enabled,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              covers
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (probe_addr >= lo_addr);
        below_hi = (probe_addr <= hi_addr);
        covers   = enabled && above_lo && below_hi;
    end

endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
    import mpu_pkg::*;
(
    input  logic [31:0] perm_word,
    input  logic [2:0]  master,
    input  acc_kind_e   kind,
    input  logic        super_mode,
    output logic        allow
);

    logic [1:0] pair;
    logic [5:0] group;
    rwx_t       user_bits;
    rwx_t       eff_bits;
    sup_mode_e  sel;
    int         lm;

    always_comb begin
        lm        = int'(master[1:0]);
        pair      = perm_word[24 + 2*lm +: 2];
        group     = perm_word[6*lm +: 6];
        user_bits = rwx_t'(group[2:0]);
        sel       = sup_mode_e'(group[4:3]);
        eff_bits  = user_bits;

        if (super_mode) begin
            unique case (sel)
                SUP_RWX:     eff_bits = '{r: 1'b1, w: 1'b1, x: 1'b1};
                SUP_RX:      eff_bits = '{r: 1'b1, w: 1'b0, x: 1'b1};
                SUP_RW:      eff_bits = '{r: 1'b1, w: 1'b1, x: 1'b0};
                SUP_AS_USER: eff_bits = user_bits;
                default:     eff_bits = user_bits;
            endcase
        end

        if (master[2]) begin
            // pair[1] read enable, pair[0] write enable
            allow = (kind == ACC_WRITE) ? pair[0] : pair[1];
        end else begin
            unique case (kind)
                ACC_READ:  allow = eff_bits.r;
                ACC_WRITE: allow = eff_bits.w;
                ACC_EXEC:  allow = eff_bits.x;
                default:   allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 32,
    parameter int CFG_AW      = 12,
    parameter int DESC_BASE   = 'h400,
    parameter int ALT_BASE    = 'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [2:0]        acc_master,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_super,
    output logic              acc_grant,
    output logic              acc_error
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] start_q;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] end_q;
    logic [NUM_REGIONS-1:0][31:0]       perm_q;
    logic [NUM_REGIONS-1:0]             valid_q;
    logic [NUM_REGIONS-1:0]             covers;
    logic [NUM_REGIONS-1:0]             allows;
    logic [NUM_REGIONS-1:0]             region_ok;
    acc_kind_e                          kind;
    logic                               any_ok;

    mpu_desc_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .CFG_AW      (CFG_AW),
        .DESC_BASE   (DESC_BASE),
        .ALT_BASE    (ALT_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .start_o   (start_q),
        .end_o     (end_q),
        .perm_o    (perm_q),
        .valid_o   (valid_q)
    );

    always_comb begin
        if (acc_write)      kind = ACC_WRITE;
        else if (acc_fetch) kind = ACC_EXEC;
        else                kind = ACC_READ;
    end

    for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_region
        mpu_region_match #(.ADDR_W(ADDR_W)) u_match (
            .lo_addr    (start_q[n]),
            .hi_addr    (end_q[n]),
            .enabled    (valid_q[n]),
            .probe_addr (acc_addr),
            .covers     (covers[n])
        );

        mpu_perm_decode u_perm (
            .perm_word  (perm_q[n]),
            .master     (acc_master),
            .kind       (kind),
            .super_mode (acc_super),
            .allow      (allows[n])
        );

        assign region_ok[n] = covers[n] && allows[n];
    end

    always_comb begin
        any_ok    = |region_ok;
        acc_grant = acc_valid && any_ok;
        acc_error = acc_valid && !any_ok;
    end

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = 12,
    parameter int DESC_BASE   = 'h400,
    parameter int ALT_BASE    = 'h800
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [CFG_AW-1:0]      cfg_addr,
    input logic [31:0]            cfg_wdata,
    input logic                   acc_valid,
    input logic                   acc_grant,
    input logic                   acc_error,
    input logic [NUM_REGIONS-1:0] region_valid
);

    a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_grant != acc_error));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_error));

    a_r5_uncovered_error: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && region_valid == '0) |-> acc_error);

    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_chk
        localparam logic [CFG_AW-1:0] A0 = CFG_AW'(DESC_BASE + 16*k);
        localparam logic [CFG_AW-1:0] A1 = CFG_AW'(DESC_BASE + 16*k + 4);
        localparam logic [CFG_AW-1:0] A2 = CFG_AW'(DESC_BASE + 16*k + 8);
        localparam logic [CFG_AW-1:0] A3 = CFG_AW'(DESC_BASE + 16*k + 12);
        localparam logic [CFG_AW-1:0] AA = CFG_AW'(ALT_BASE + 4*k);

        a_r3_addr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (cfg_addr == A0 || cfg_addr == A1 || cfg_addr == A2))
            |=> !region_valid[k]);

        a_r3_ctrl_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == A3) |=> (region_valid[k] == $past(cfg_wdata[0])));

        a_r4_alias_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AA) |=> $stable(region_valid[k]));
    end

endmodule

bind mpu_region_checker mpu_region_checker_sva #(
    .NUM_REGIONS (NUM_REGIONS),
    .CFG_AW      (CFG_AW),
    .DESC_BASE   (DESC_BASE),
    .ALT_BASE    (ALT_BASE)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .acc_valid    (acc_valid),
    .acc_grant    (acc_grant),
    .acc_error    (acc_error),
    .region_valid (valid_q)
);

// File: tb/mpu_region_checker_tb_top.sv
module mpu_region_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_master = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_super = 1'b0;
    logic        acc_grant;
    logic        acc_error;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mpu_region_checker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .acc_valid  (acc_valid),
        .acc_master (acc_master),
        .acc_addr   (acc_addr),
        .acc_write  (acc_write),
        .acc_fetch  (acc_fetch),
        .acc_super  (acc_super),
        .acc_grant  (acc_grant),
        .acc_error  (acc_error)
    );

    function automatic logic [11:0] dw(int n, int w);
        return 12'(12'h400 + 16*n + 4*w);
    endfunction

    function automatic logic [11:0] alias_a(int n);
        return 12'(12'h800 + 4*n);
    endfunction

    function automatic logic [31:0] hi_pair(int m, bit re, bit we);
        logic [31:0] p = '0;
        p[2*m+17] = re;
        p[2*m+16] = we;
        return p;
    endfunction

    function automatic logic [31:0] lo_grp(int m, bit pe, logic [1:0] sm, logic [2:0] u);
        logic [31:0] p = '0;
        p[6*m +: 6] = {pe, sm, u};
        return p;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic acc_chk(string req, int m, logic [31:0] a, bit w, bit f, bit s, bit exp_grant);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = 3'(m); acc_addr = a;
        acc_write = w; acc_fetch = f; acc_super = s;
        #1;
        chk(req, {30'b0, acc_grant, acc_error}, {30'b0, exp_grant, !exp_grant});
    endtask

    task automatic region(int n, logic [31:0] lo, logic [31:0] hi, logic [31:0] perm);
        wr(dw(n, 0), lo);
        wr(dw(n, 1), hi);
        wr(dw(n, 2), perm);
        wr(dw(n, 3), 32'h1);
    endtask

    task automatic clear_all();
        for (int n = 0; n < 4; n++) wr(dw(n, 3), 32'h0);
    endtask

    task automatic t_reset();
        for (int n = 0; n < 4; n += 3)
            for (int w = 0; w < 4; w++) rd_chk("R1 reset word", dw(n, w), 32'h0);
        acc_chk("R1 reset access", 0, 32'h0, 0, 0, 1, 0);
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        chk("R11 idle", {30'b0, acc_grant, acc_error}, 32'h0);
    endtask

    task automatic t_regmap();
        wr(dw(2, 0), 32'hA000_0000);
        wr(dw(2, 1), 32'hA000_FFFF);
        wr(dw(2, 2), 32'h1234_5678);
        wr(dw(2, 3), 32'h1);
        rd_chk("R2 start", dw(2, 0), 32'hA000_0000);
        rd_chk("R2 end", dw(2, 1), 32'hA000_FFFF);
        rd_chk("R2 perm", dw(2, 2), 32'h1234_5678);
        rd_chk("R2 ctrl", dw(2, 3), 32'h1);
        wr(12'h7FC, 32'hFFFF_FFFF);
        rd_chk("R2 unmapped", 12'h7FC, 32'h0);
        wr(dw(2, 0) + 12'h1, 32'h5555_5555);
        rd_chk("R2 misaligned ignored", dw(2, 0), 32'hA000_0000);
    endtask

    task automatic t_valid_rules();
        wr(dw(2, 3), 32'h1);
        wr(dw(2, 0), 32'hA000_0000);
        rd_chk("R3 start clears", dw(2, 3), 32'h0);
        wr(dw(2, 3), 32'h1);
        wr(dw(2, 1), 32'hA000_FFFF);
        rd_chk("R3 end clears", dw(2, 3), 32'h0);
        wr(dw(2, 3), 32'h1);
        wr(dw(2, 2), 32'h0);
        rd_chk("R3 perm clears", dw(2, 3), 32'h0);
        wr(dw(2, 3), 32'hFFFF_FFFE);
        rd_chk("R3 ctrl bit0 zero", dw(2, 3), 32'h0);
    endtask

    task automatic t_alias();
        region(1, 32'h0, 32'h0, 32'h0);
        wr(alias_a(1), 32'hCAFE_0123);
        rd_chk("R4 alias perm", dw(1, 2), 32'hCAFE_0123);
        rd_chk("R4 alias valid kept", dw(1, 3), 32'h1);
        rd_chk("R4 alias readback", alias_a(1), 32'hCAFE_0123);
        wr(dw(1, 3), 32'h0);
        wr(alias_a(1), 32'h0);
        rd_chk("R4 alias keeps disabled", dw(1, 3), 32'h0);
    endtask

    task automatic t_range();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, 32'hFFFF_FFFF);
        acc_chk("R5 low bound", 0, 32'h1000, 0, 0, 1, 1);
        acc_chk("R5 high bound", 0, 32'h1FFF, 0, 0, 1, 1);
        acc_chk("R5 below", 0, 32'h0FFF, 0, 0, 1, 0);
        acc_chk("R5 above", 0, 32'h2000, 0, 0, 1, 0);
        wr(dw(0, 3), 32'h0);
        acc_chk("R5 disabled", 0, 32'h1500, 0, 0, 1, 0);
    endtask

    task automatic t_high_masters();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, hi_pair(5, 1, 0) | hi_pair(7, 0, 1));
        acc_chk("R6 m5 read", 5, 32'h1100, 0, 0, 0, 1);
        acc_chk("R6 m5 write", 5, 32'h1100, 1, 0, 1, 0);
        acc_chk("R6 m5 fetch", 5, 32'h1100, 0, 1, 1, 1);
        acc_chk("R6 m4 read", 4, 32'h1100, 0, 0, 1, 0);
        acc_chk("R6 m7 write", 7, 32'h1100, 1, 0, 0, 1);
        acc_chk("R6 m7 read", 7, 32'h1100, 0, 0, 1, 0);
    endtask

    task automatic t_low_user();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, lo_grp(2, 1, 2'd0, 3'b010));
        acc_chk("R8 user read", 2, 32'h1100, 0, 0, 0, 0);
        acc_chk("R8 user write", 2, 32'h1100, 1, 0, 0, 1);
        acc_chk("R8 user exec", 2, 32'h1100, 0, 1, 0, 0);
        acc_chk("R8 write beats fetch", 2, 32'h1100, 1, 1, 0, 1);
        acc_chk("R7 other group", 1, 32'h1100, 1, 0, 0, 0);
        wr(alias_a(0), lo_grp(2, 0, 2'd0, 3'b010));
        acc_chk("R7 spare flag no effect", 2, 32'h1100, 1, 0, 0, 1);
    endtask

    task automatic t_super();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, lo_grp(3, 0, 2'd1, 3'b000));
        acc_chk("R9 rx read", 3, 32'h1100, 0, 0, 1, 1);
        acc_chk("R9 rx write", 3, 32'h1100, 1, 0, 1, 0);
        acc_chk("R9 rx exec", 3, 32'h1100, 0, 1, 1, 1);
        wr(alias_a(0), lo_grp(3, 0, 2'd2, 3'b000));
        acc_chk("R9 rw write", 3, 32'h1100, 1, 0, 1, 1);
        acc_chk("R9 rw exec", 3, 32'h1100, 0, 1, 1, 0);
        wr(alias_a(0), lo_grp(3, 0, 2'd3, 3'b001));
        acc_chk("R9 user exec", 3, 32'h1100, 0, 1, 1, 1);
        acc_chk("R9 user read", 3, 32'h1100, 0, 0, 1, 0);
        wr(alias_a(0), lo_grp(3, 0, 2'd0, 3'b000));
        acc_chk("R9 rwx write", 3, 32'h1100, 1, 0, 1, 1);
        acc_chk("R8 user still denied", 3, 32'h1100, 1, 0, 0, 0);
    endtask

    task automatic t_overlap();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, lo_grp(0, 0, 2'd3, 3'b100));
        region(1, 32'h1800, 32'h27FF, lo_grp(0, 0, 2'd3, 3'b010));
        acc_chk("R10 overlap write", 0, 32'h1900, 1, 0, 0, 1);
        acc_chk("R10 overlap read", 0, 32'h1900, 0, 0, 0, 1);
        acc_chk("R10 r0 only write", 0, 32'h1200, 1, 0, 0, 0);
        acc_chk("R10 r1 only read", 0, 32'h2100, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        clear_all();
        region(0, 32'h1000, 32'h1FFF, hi_pair(6, 1, 1));
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = dw(0, 0); cfg_wdata = 32'h1000;
        acc_valid = 1'b1; acc_master = 3'd6; acc_addr = 32'h1100;
        acc_write = 1'b0; acc_fetch = 1'b0; acc_super = 1'b0;
        #1;
        chk("R12 old state in write cycle", {30'b0, acc_grant, acc_error}, 32'h2);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R12 region off after write", {30'b0, acc_grant, acc_error}, 32'h1);
        wr(dw(0, 3), 32'h1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = alias_a(0); cfg_wdata = hi_pair(6, 0, 1);
        acc_write = 1'b0;
        #1;
        chk("R12 alias old perm", {30'b0, acc_grant, acc_error}, 32'h2);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R12 alias new perm", {30'b0, acc_grant, acc_error}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_valid_rules();
        t_alias();
        t_range();
        t_high_masters();
        t_low_user();
        t_super();
        t_overlap();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule